// File: doc/BRIEF.md
# Clock Source Select and Divider Unit

This block is a small bank of byte registers on a plain address/data bus. It picks the source for the main system clock and the subsystem clock, and it divides the main, subsystem and auxiliary clocks by 1, 2, 4 or 8. The three source clocks reach the block as single-cycle tick inputs in the block's own clock domain: the DCO tick, the second-crystal tick and the low-frequency tick. The outputs are one-cycle enable pulses at the divided rates.

The block also drives the second oscillator's enable. That line stays high whenever the main or the subsystem clock uses the second oscillator, whatever the off bit holds. It keeps an oscillator-fault flag, which the fault inputs set, and the enable for that fault. An interrupt request is raised when the flag and the enable are both set.

Writes happen when `wr` is high at a clock edge. Reads are combinational from `addr`.

Top module: `clk_sel_div`

## Requirements
- R1: After reset the registers read as follows. Address 57h reads 87h, 58h reads 00h, 02h reads 02h and 00h reads 00h. Address 53h reads 04h OR'd with {xt2_fault, lf_fault} in bits 1:0.
- R2: A write to 57h or 58h stores all 8 bits. A write to 53h stores bits 7:2 only. Bits 1:0 of 53h always read as {xt2_fault, lf_fault}, and writes to them are ignored. Bits other than bit 1 of 00h and 02h read 0. Any other address reads 00h.
- R3: Bits 7:6 of register 58h select the main-clock source. Codes 00 and 01 select dco_tick, 10 selects xt2_tick and 11 selects lf_tick.
- R4: Bit 3 of register 58h selects the subsystem-clock source. A 0 selects dco_tick and a 1 selects xt2_tick. The auxiliary clock always uses lf_tick.
- R5: Each clock has a 3-bit count of the ticks of its selected source, starting at 0 after reset. The divider code k gives /2^k: 00 is /1, 01 is /2, 10 is /4 and 11 is /8. An enable pulse is output in the same cycle as a source tick when the low k bits of the count are all ones.
- R6: The divider fields are bits 5:4 of 58h for the main clock, bits 2:1 of 58h for the subsystem clock and bits 5:4 of 57h for the auxiliary clock. A new divider code takes effect only after the tick at which the count reaches 7.
- R7: xt2_on is high when bit 7 of 57h is 0, or when the main clock selects code 10, or when bit 3 of 58h is 1.
- R8: The fault flag is bit 1 of 02h. It is set in every cycle in which lf_fault or xt2_fault is high. A software write of bit 1 to 02h takes effect only while both fault inputs are low.
- R9: The fault enable is bit 1 of 00h. irq is high exactly when the flag and the enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for addr |
| dco_tick | input | 1 | DCO source tick |
| xt2_tick | input | 1 | Second-crystal source tick |
| lf_tick | input | 1 | Low-frequency source tick |
| lf_fault | input | 1 | Low-frequency oscillator fault |
| xt2_fault | input | 1 | Second oscillator fault |
| mclk_en | output | 1 | Divided main-clock enable |
| smclk_en | output | 1 | Divided subsystem-clock enable |
| aclk_en | output | 1 | Divided auxiliary-clock enable |
| xt2_on | output | 1 | Second oscillator enable |
| irq | output | 1 | Oscillator-fault interrupt request |

## Verification
The hardest case to reach is a divider change that lands in the middle of a count. The old divider must keep its phase until the count wraps, while source switches move the same counter onto another tick stream. Random writes to 57h and 58h are mixed with random ticks on all three sources, so code changes arrive at every count phase. A bench model tracks each count and each active code, and predicts the exact wrap at which the new code applies. Directed steps cover the fault flag: a clearing write while a fault input is high, then the same write after the inputs drop.

// File: rtl/clk_sel_div.sv
module clk_sel_div #(
  parameter logic [7:0] A_CTL1 = 8'h57,
  parameter logic [7:0] A_CTL2 = 8'h58,
  parameter logic [7:0] A_CTL3 = 8'h53,
  parameter logic [7:0] A_IE   = 8'h00,
  parameter logic [7:0] A_IFG  = 8'h02,
  parameter int CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       dco_tick,
  input  logic       xt2_tick,
  input  logic       lf_tick,
  input  logic       lf_fault,
  input  logic       xt2_fault,
  output logic       mclk_en,
  output logic       smclk_en,
  output logic       aclk_en,
  output logic       xt2_on,
  output logic       irq
);
  localparam int NCLK = 3;
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [7:0] ctl1, ctl2;
  logic [5:0] ctl3_hi;
  logic       fault_ie, fault_flag;
  logic       m_src;
  logic [NCLK-1:0] src, pulse;
  logic [1:0] req [NCLK];
  logic [1:0] act [NCLK];
  logic [CNT_W-1:0] cnt [NCLK];

  wire any_fault = lf_fault | xt2_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1     <= 8'h87;
      ctl2     <= 8'h00;
      ctl3_hi  <= 6'h01;
      fault_ie <= 1'b0;
    end else if (wr) begin
      case (addr)
        A_CTL1: ctl1     <= wdata;
        A_CTL2: ctl2     <= wdata;
        A_CTL3: ctl3_hi  <= wdata[7:2];
        A_IE:   fault_ie <= wdata[1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  fault_flag <= 1'b1;
    else if (any_fault)          fault_flag <= 1'b1;
    else if (wr && addr == A_IFG) fault_flag <= wdata[1];
  end

  always_comb begin
    case (ctl2[7:6])
      2'b10:   m_src = xt2_tick;
      2'b11:   m_src = lf_tick;
      default: m_src = dco_tick;
    endcase
  end

  assign src    = {lf_tick, ctl2[3] ? xt2_tick : dco_tick, m_src};
  assign req[0] = ctl2[5:4];
  assign req[1] = ctl2[2:1];
  assign req[2] = ctl1[5:4];

  for (genvar g = 0; g < NCLK; g++) begin : g_div
    wire [CNT_W-1:0] mask = ~(CNT_TOP << act[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[g] <= '0;
        act[g] <= 2'b00;
      end else if (src[g]) begin
        cnt[g] <= cnt[g] + 1'b1;
        if (cnt[g] == CNT_TOP) act[g] <= req[g];
      end
    end
    assign pulse[g] = src[g] & ((cnt[g] & mask) == mask);
  end

  assign mclk_en  = pulse[0];
  assign smclk_en = pulse[1];
  assign aclk_en  = pulse[2];
  assign xt2_on   = ~ctl1[7] | (ctl2[7:6] == 2'b10) | ctl2[3];
  assign irq      = fault_flag & fault_ie;

  always_comb begin
    case (addr)
      A_CTL1:  rdata = ctl1;
      A_CTL2:  rdata = ctl2;
      A_CTL3:  rdata = {ctl3_hi, xt2_fault, lf_fault};
      A_IE:    rdata = {6'b0, fault_ie, 1'b0};
      A_IFG:   rdata = {6'b0, fault_flag, 1'b0};
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/clk_sel_div_chk.sv
module clk_sel_div_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] addr,
  input logic       wr,
  input logic [7:0] wdata,
  input logic       lf_fault,
  input logic       xt2_fault,
  input logic [7:0] ctl2,
  input logic [5:0] ctl3_hi,
  input logic       fault_flag,
  input logic       fault_ie,
  input logic       m_src,
  input logic [1:0] act_m,
  input logic [2:0] cnt_m,
  input logic       xt2_on,
  input logic       irq
);
  a_r2_ctl3_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 8'h53) |=> ctl3_hi == $past(wdata[7:2]));
  a_r6_change_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (act_m != $past(act_m)) |-> ($past(cnt_m) == 3'd7 && $past(m_src)));
  a_r7_xt2_kept_on: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl2[7:6] == 2'b10 || ctl2[3]) |-> xt2_on);
  a_r8_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (lf_fault || xt2_fault) |=> fault_flag);
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fault_ie && fault_flag));
endmodule

bind clk_sel_div clk_sel_div_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata),
  .lf_fault(lf_fault), .xt2_fault(xt2_fault), .ctl2(ctl2), .ctl3_hi(ctl3_hi),
  .fault_flag(fault_flag), .fault_ie(fault_ie), .m_src(m_src),
  .act_m(act[0]), .cnt_m(cnt[0]), .xt2_on(xt2_on), .irq(irq)
);

// File: tb/clk_sel_div_test.sv
module clk_sel_div_test;
  localparam int PER = 10;
  localparam int NSTEP = 6000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic wr = 1'b0, dco_tick = 1'b0, xt2_tick = 1'b0, lf_tick = 1'b0;
  logic lf_fault = 1'b0, xt2_fault = 1'b0;
  logic [7:0] rdata;
  logic mclk_en, smclk_en, aclk_en, xt2_on, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_c1, m_c2;
  logic [5:0] m_c3;
  logic m_ie, m_fl;
  logic [2:0] m_cnt [3];
  logic [1:0] m_act [3];

  always #(PER/2) clk = ~clk;

  clk_sel_div uut (.*);

  function automatic logic [2:0] f_mask(input logic [1:0] k);
    return ~(3'b111 << k);
  endfunction

  function automatic logic [7:0] f_read(input logic [7:0] a);
    case (a)
      8'h57: return m_c1;
      8'h58: return m_c2;
      8'h53: return {m_c3, xt2_fault, lf_fault};
      8'h00: return {6'b0, m_ie, 1'b0};
      8'h02: return {6'b0, m_fl, 1'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] f_src();
    logic ms;
    case (m_c2[7:6])
      2'b10: ms = xt2_tick;
      2'b11: ms = lf_tick;
      default: ms = dco_tick;
    endcase
    return {lf_tick, m_c2[3] ? xt2_tick : dco_tick, ms};
  endfunction

  function automatic logic f_pulse(input int i);
    logic [2:0] s = f_src();
    return s[i] && ((m_cnt[i] & f_mask(m_act[i])) == f_mask(m_act[i]));
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_c1 = 8'h87; m_c2 = 8'h00; m_c3 = 6'h01; m_ie = 1'b0; m_fl = 1'b1;
    for (int i = 0; i < 3; i++) begin m_cnt[i] = 3'd0; m_act[i] = 2'd0; end
  endtask

  task automatic step(input string rtag);
    logic [2:0] s;
    logic [1:0] rq [3];
    #(PER/4);
    chk(rtag, rdata, f_read(addr));
    chk("R3 R5 R6 mclk_en", {7'b0, mclk_en}, {7'b0, f_pulse(0)});
    chk("R4 R5 R6 smclk_en", {7'b0, smclk_en}, {7'b0, f_pulse(1)});
    chk("R4 R5 R6 aclk_en", {7'b0, aclk_en}, {7'b0, f_pulse(2)});
    chk("R7 xt2_on", {7'b0, xt2_on},
        {7'b0, ~m_c1[7] | (m_c2[7:6] == 2'b10) | m_c2[3]});
    chk("R9 irq", {7'b0, irq}, {7'b0, m_fl & m_ie});
    @(posedge clk);
    s = f_src();
    rq[0] = m_c2[5:4]; rq[1] = m_c2[2:1]; rq[2] = m_c1[5:4];
    for (int i = 0; i < 3; i++)
      if (s[i]) begin
        if (m_cnt[i] == 3'd7) m_act[i] = rq[i];
        m_cnt[i] = m_cnt[i] + 3'd1;
      end
    if (lf_fault || xt2_fault) m_fl = 1'b1;
    else if (wr && addr == 8'h02) m_fl = wdata[1];
    if (wr)
      case (addr)
        8'h57: m_c1 = wdata;
        8'h58: m_c2 = wdata;
        8'h53: m_c3 = wdata[7:2];
        8'h00: m_ie = wdata[1];
        default: ;
      endcase
    @(negedge clk);
  endtask

  task automatic drive(input logic [7:0] a, input logic w, input logic [7:0] d,
                       input logic [2:0] t, input logic [1:0] f);
    addr = a; wr = w; wdata = d;
    {lf_tick, xt2_tick, dco_tick} = t;
    {xt2_fault, lf_fault} = f;
  endtask

  function automatic logic [7:0] pick_addr(input int r);
    case (r % 6)
      0: return 8'h57;
      1: return 8'h58;
      2: return 8'h53;
      3: return 8'h00;
      4: return 8'h02;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(PER * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    drive(8'h57, 1'b0, 8'h00, 3'b000, 2'b01);
    #(PER * 3);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    drive(8'h57, 1'b0, 8'h00, 3'b000, 2'b01); step("R1 ctl1");
    drive(8'h58, 1'b0, 8'h00, 3'b000, 2'b00); step("R1 ctl2");
    drive(8'h53, 1'b0, 8'h00, 3'b000, 2'b01); step("R1 ctl3");
    drive(8'h02, 1'b0, 8'h00, 3'b000, 2'b00); step("R1 flag");
    drive(8'h00, 1'b0, 8'h00, 3'b000, 2'b00); step("R1 enable");
    // R2 status bits ignore writes
    drive(8'h53, 1'b1, 8'hFF, 3'b000, 2'b00); step("R2 ctl3 write");
    drive(8'h53, 1'b0, 8'h00, 3'b000, 2'b10); step("R2 ctl3 readback");
    // R8 clear blocked while fault high, allowed once low; R9 irq follows
    drive(8'h00, 1'b1, 8'hFF, 3'b000, 2'b00); step("R9 set enable");
    drive(8'h02, 1'b1, 8'h00, 3'b000, 2'b01); step("R8 clear during fault");
    drive(8'h02, 1'b0, 8'h00, 3'b000, 2'b00); step("R8 flag held");
    drive(8'h02, 1'b1, 8'h00, 3'b000, 2'b00); step("R8 clear");
    drive(8'h02, 1'b0, 8'h00, 3'b000, 2'b00); step("R8 flag cleared");
    // R6 change /8 mid-count on the main clock, then run ticks across the wrap
    drive(8'h58, 1'b1, 8'h30, 3'b001, 2'b00); step("R6 write div");
    for (int i = 0; i < 20; i++) begin
      drive(8'h58, 1'b0, 8'h00, 3'b001, 2'b00); step("R6 run");
    end
    // R7 off bit with and without xt2 in use
    drive(8'h58, 1'b1, 8'h00, 3'b000, 2'b00); step("R7 deselect");
    drive(8'h57, 1'b1, 8'h80, 3'b000, 2'b00); step("R7 off");
    drive(8'h58, 1'b1, 8'h80, 3'b000, 2'b00); step("R7 main uses xt2");
    drive(8'h58, 1'b1, 8'h08, 3'b000, 2'b00); step("R7 sub uses xt2");
    for (int n = 0; n < NSTEP; n++) begin
      int r = int'($urandom);
      drive(pick_addr(r), ($urandom % 4) == 0, 8'($urandom), 3'($urandom),
            {($urandom % 16) == 0, ($urandom % 16) == 0});
      step("R2 R8 random read");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule